// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This receiver turns four serial audio lines into a bank of sixteen parallel 24-bit channel words. All four lines share one bit clock and one frame clock. Both clocks come from outside the block and are only ever sampled, never driven. The bit clock, the frame clock and the data lines are brought into the system clock domain by two-stage synchronizers. Every bit-clock rising edge is then detected in that domain, and the frame-clock level and the four data levels are captured at that edge.

A three-bit format field selects how the lines are interpreted. In the two-channel formats (I2S and left-justified) every line carries a left and a right sample per frame. In the two TDM formats the frame clock becomes a frame-sync pulse. Sixteen channels then arrive either as two groups of eight on lines 3 and 2, or as one run of sixteen on line 2. Each slot is 32 bit clocks long, and only its first 24 bits (MSB first) form the sample. Finished words collect in a staging store. At each frame boundary that closes a correctly sized frame, they are copied into the output bank in one step, together with a one-cycle valid pulse. A boundary that closes a frame of the wrong length sets a sticky error flag.

Top module: `tdm_audio_rx`

## Requirements
- R1: After reset, `frameValid` and `frameErr` are 0, all of `chanData` is 0, and the format is I2S (code 0).
- R2: A write with `ctrlWdata` of 0 selects I2S, 1 selects left-justified, 2 selects two-wire TDM and 3 selects one-wire TDM. A write with a code from 4 to 7 changes nothing: the format, the error flag and the framing all stay as they were.
- R3: In I2S, a falling frame-clock edge opens the left slot and a rising edge opens the right slot. The MSB is on the second bit clock of each slot. Line p feeds channel 2p (left) and channel 2p+1 (right), and channels 8 to 15 read 0.
- R4: In left-justified format, a rising frame-clock edge opens the left slot and a falling edge opens the right slot. The MSB is on the same bit clock as the edge. The channel mapping is the same as in R3.
- R5: Each slot is 32 bit clocks wide. Its first 24 bits form the sample, MSB first, and the remaining 8 bits have no effect on any channel.
- R6: In two-wire TDM, a rising frame-clock edge starts an 8-slot frame, with the MSB of slot 0 on that bit clock. Slot s on line 3 goes to channel s, and slot s on line 2 goes to channel 8+s.
- R7: In one-wire TDM, a rising frame-clock edge starts a 16-slot frame on line 2, and slot s goes to channel s.
- R8: At a frame boundary that closes a frame of the expected length (64, 256 or 512 bit clocks for the two-channel, two-wire and one-wire formats), all sixteen words update together and `frameValid` is high for exactly one clock. The first boundary after reset or after an accepted write does not pulse. Between pulses `chanData` holds its value.
- R9: A boundary that closes a frame of any other length sets `frameErr` and does not update `chanData`. The flag stays set until reset or an accepted write.
- R10: In both TDM formats, lines 0 and 1 have no effect on any channel. In one-wire TDM, line 3 has no effect either.
- R11: An accepted write clears `frameErr` and restarts framing, so that the next boundary only marks the start of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWe | input | 1 | Format register write strobe |
| ctrlWdata | input | 3 | Format code written with the strobe |
| bclkIn | input | 1 | External bit clock, sampled only |
| lrclkIn | input | 1 | External frame clock / frame sync, sampled only |
| sdataIn | input | 4 | Serial data lines 0 to 3 |
| chanData | output | 384 | Sixteen 24-bit words, channel c at bits 24c+23 down to 24c |
| frameValid | output | 1 | One-clock pulse when the bank updates |
| frameErr | output | 1 | Sticky frame-length error |

## Verification
The frame-length check and the buffer commit both act on the same bit-clock edge: the one that starts a frame. A stream with a deliberately short or long frame placed between good frames makes that edge either set the error flag or update the bank, never both. Each such run is judged at the ports by the pulse count, the error flag and the final contents of the bank. A second collision, between a register write and an active stream, is provoked by writing a reserved code and then a valid one while the flag is set. The bench checks that the first write leaves the flag and the decoding untouched and that the second clears the flag.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  localparam int NUM_PINS   = 4;
  localparam int NUM_CH     = 16;
  localparam int SLOT_IDX_W = $clog2(NUM_CH);
  localparam int TDM_PIN_LO = 3;  // channels 0..7 in two-wire TDM
  localparam int TDM_PIN_HI = 2;  // channels 8..15, or all in one-wire TDM

  typedef enum logic [2:0] {
    FMT_I2S   = 3'd0,
    FMT_LJ    = 3'd1,
    FMT_TDM2W = 3'd2,
    FMT_TDM1W = 3'd3
  } fmtE;

  // strobes from the framing control to the datapath
  typedef struct packed {
    logic                  sample;    // one bit captured on every line
    logic                  wordDone;  // the current bit closes a sample word
    logic [SLOT_IDX_W-1:0] slotIdx;   // slot that the finished word belongs to
    logic                  commit;    // copy the staging store to the output bank
    fmtE                   fmt;
  } rxStrbT;

endpackage

// File: rtl/tdm_rx_ctrl.sv
module tdm_rx_ctrl
  import tdm_rx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWe,
  input  logic [2:0]          ctrlWdata,
  input  logic                bclkIn,
  input  logic                lrclkIn,
  input  logic [NUM_PINS-1:0] sdataIn,
  output rxStrbT              strb,
  output logic [NUM_PINS-1:0] pinBits,
  output logic                frameErr
);

  localparam int SLOT_SH = $clog2(SLOT_BITS);
  localparam int CNT_W   = $clog2(SLOT_BITS * NUM_CH) + 1;
  localparam int IDX_W   = CNT_W - SLOT_SH;

  logic [2:0]                    bclkSync;
  logic [1:0]                    lrSync;
  logic [1:0][NUM_PINS-1:0]      dataSync;
  fmtE                           fmtReg;
  logic                          prevLr, edgeQ, seenFrame, errReg;
  logic [CNT_W-1:0]              bitCnt, nextCnt, bitIdx, expBits;
  logic [IDX_W-1:0]              slotNum, slotLimit;
  logic [SLOT_SH-1:0]            slotPos;
  logic                          bclkRise, lrNow, edgeNow, startNow, lenOk, accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkSync <= '0;
      lrSync   <= '0;
      dataSync <= '0;
    end else begin
      bclkSync <= {bclkSync[1:0], bclkIn};
      lrSync   <= {lrSync[0], lrclkIn};
      dataSync <= {dataSync[0], sdataIn};
    end
  end

  assign bclkRise = bclkSync[1] & ~bclkSync[2];
  assign lrNow    = lrSync[1];
  assign pinBits  = dataSync[1];
  assign accept   = ctrlWe && (ctrlWdata <= 3'd3);

  always_comb begin
    edgeNow   = ~prevLr & lrNow;
    expBits   = CNT_W'(2 * SLOT_BITS);
    slotLimit = IDX_W'(2);
    unique case (fmtReg)
      FMT_I2S:   edgeNow = prevLr & ~lrNow;
      FMT_LJ:    ;
      FMT_TDM2W: begin
        expBits   = CNT_W'(8 * SLOT_BITS);
        slotLimit = IDX_W'(8);
      end
      FMT_TDM1W: begin
        expBits   = CNT_W'(16 * SLOT_BITS);
        slotLimit = IDX_W'(16);
      end
      default:   edgeNow = prevLr & ~lrNow;
    endcase
  end

  assign startNow = (fmtReg == FMT_I2S) ? edgeQ : edgeNow;
  assign nextCnt  = (&bitCnt) ? bitCnt : bitCnt + 1'b1;
  assign bitIdx   = startNow ? '0 : nextCnt;
  assign lenOk    = (nextCnt == expBits);
  assign slotNum  = bitIdx[CNT_W-1:SLOT_SH];
  assign slotPos  = bitIdx[SLOT_SH-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fmtReg    <= FMT_I2S;
      prevLr    <= 1'b0;
      edgeQ     <= 1'b0;
      bitCnt    <= '0;
      seenFrame <= 1'b0;
      errReg    <= 1'b0;
    end else begin
      if (bclkRise) begin
        prevLr <= lrNow;
        bitCnt <= bitIdx;
      end
      if (accept) begin
        fmtReg    <= fmtE'(ctrlWdata);
        seenFrame <= 1'b0;
        errReg    <= 1'b0;
        edgeQ     <= 1'b0;
      end else if (bclkRise) begin
        edgeQ <= edgeNow;
        if (startNow) begin
          seenFrame <= 1'b1;
          if (seenFrame && !lenOk) errReg <= 1'b1;
        end
      end
    end
  end

  assign strb.sample   = bclkRise;
  assign strb.wordDone = bclkRise && !accept && (slotPos == SLOT_SH'(SAMPLE_W - 1))
                         && (slotNum < slotLimit);
  assign strb.slotIdx  = slotNum[SLOT_IDX_W-1:0];
  assign strb.commit   = bclkRise && !accept && startNow && seenFrame && lenOk;
  assign strb.fmt      = fmtReg;
  assign frameErr      = errReg;

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && !(ctrlWe && ctrlWdata <= 3'd3)) |=> frameErr);

  assert_write_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && ctrlWdata <= 3'd3) |=> !frameErr);

  assert_reserved_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && ctrlWdata > 3'd3) |=> $stable(fmtReg));

  assert_commit_on_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> !frameErr || $past(frameErr));

endmodule

// File: rtl/tdm_rx_datapath.sv
module tdm_rx_datapath
  import tdm_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rxStrbT                       strb,
  input  logic [NUM_PINS-1:0]          pinBits,
  output logic [NUM_CH*SAMPLE_W-1:0]   chanData,
  output logic                         frameValid
);

  localparam int TWO_CH_USED = 2 * NUM_PINS;

  logic [SAMPLE_W-1:0] shiftReg [NUM_PINS];
  logic [SAMPLE_W-1:0] wordNow  [NUM_PINS];
  logic [SAMPLE_W-1:0] stage    [NUM_CH];
  logic [SAMPLE_W-1:0] outBuf   [NUM_CH];
  logic                twoCh;
  int                  usedCh;

  assign twoCh  = (strb.fmt != FMT_TDM2W) && (strb.fmt != FMT_TDM1W);
  assign usedCh = twoCh ? TWO_CH_USED : NUM_CH;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            shiftReg[p] <= '0;
      else if (strb.sample) shiftReg[p] <= {shiftReg[p][SAMPLE_W-2:0], pinBits[p]};
    end
    assign wordNow[p] = {shiftReg[p][SAMPLE_W-2:0], pinBits[p]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) stage[c] <= '0;
    end else if (strb.wordDone) begin
      unique case (strb.fmt)
        FMT_TDM2W: begin
          stage[{1'b0, strb.slotIdx[SLOT_IDX_W-2:0]}] <= wordNow[TDM_PIN_LO];
          stage[{1'b1, strb.slotIdx[SLOT_IDX_W-2:0]}] <= wordNow[TDM_PIN_HI];
        end
        FMT_TDM1W: stage[strb.slotIdx] <= wordNow[TDM_PIN_HI];
        default: begin
          for (int p = 0; p < NUM_PINS; p++)
            stage[2 * p + int'(strb.slotIdx[0])] <= wordNow[p];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) outBuf[c] <= '0;
      frameValid <= 1'b0;
    end else begin
      frameValid <= strb.commit;
      if (strb.commit) begin
        for (int c = 0; c < NUM_CH; c++)
          outBuf[c] <= (c < usedCh) ? stage[c] : '0;
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_flat
    assign chanData[c*SAMPLE_W +: SAMPLE_W] = outBuf[c];
  end

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> !frameValid);

  assert_buf_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |-> $stable(chanData));

  assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && twoCh) |-> (chanData[NUM_CH*SAMPLE_W-1:TWO_CH_USED*SAMPLE_W] == '0));

endmodule

// File: rtl/tdm_audio_rx.sv
module tdm_audio_rx
  import tdm_rx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       ctrlWe,
  input  logic [2:0]                 ctrlWdata,
  input  logic                       bclkIn,
  input  logic                       lrclkIn,
  input  logic [3:0]                 sdataIn,
  output logic [16*SAMPLE_W-1:0]     chanData,
  output logic                       frameValid,
  output logic                       frameErr
);

  rxStrbT              strb;
  logic [NUM_PINS-1:0] pinBits;

  tdm_rx_ctrl #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .bclkIn(bclkIn), .lrclkIn(lrclkIn), .sdataIn(sdataIn),
    .strb(strb), .pinBits(pinBits), .frameErr(frameErr)
  );

  tdm_rx_datapath #(.SAMPLE_W(SAMPLE_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .pinBits(pinBits),
    .chanData(chanData), .frameValid(frameValid)
  );

endmodule

// File: tb/tdm_audio_rx_test.sv
module tdm_audio_rx_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         ctrlWe = 1'b0;
  logic [2:0]   ctrlWdata = 3'd0;
  logic         bclkIn = 1'b0;
  logic         lrclkIn = 1'b0;
  logic [3:0]   sdataIn = 4'd0;
  logic [383:0] chanData;
  logic         frameValid, frameErr;

  int checks = 0;
  int failures = 0;
  int validTotal = 0;
  int doublePulse = 0;
  logic [383:0] capData = '0;
  logic lastValid = 1'b0;
  logic timedOut = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  tdm_audio_rx uut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .bclkIn(bclkIn), .lrclkIn(lrclkIn), .sdataIn(sdataIn),
    .chanData(chanData), .frameValid(frameValid), .frameErr(frameErr)
  );

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (frameValid) begin
        validTotal++;
        capData = chanData;
        if (lastValid) doublePulse++;
      end
      lastValid = frameValid;
    end else begin
      lastValid = 1'b0;
    end
  end

  // mode, frames, bad frame index, bad length, seed, expected pulses, expected error
  localparam int RUNS [6][7] = '{
    '{0, 2, 99,  0, 11, 2, 0},   // R3 I2S
    '{1, 2, 99,  0, 23, 2, 0},   // R4 left-justified
    '{2, 2, 99,  0, 35, 2, 0},   // R6 R10 two-wire TDM
    '{3, 1, 99,  0, 47, 1, 0},   // R7 R10 one-wire TDM
    '{1, 3,  1, 48, 59, 2, 1},   // R9 short frame between good ones
    '{0, 2,  0, 72, 61, 1, 1}    // R9 long first frame
  };

  function automatic logic [23:0] mkWord(input int p, input int s, input int seed);
    logic [31:0] h;
    h = (32'(seed) * 32'h9E3779B1) ^ (32'(p) * 32'h85EBCA6B) ^ (32'(s) * 32'hC2B2AE35) ^ 32'h01234567;
    h = h ^ (h >> 15);
    h = h * 32'h2C1B3C6D;
    h = h ^ (h >> 12);
    return h[23:0];
  endfunction

  function automatic logic genBit(input int p, input int i, input int seed);
    logic [23:0] w;
    int k;
    k = i % 32;
    if (k >= 24) return 1'b1;  // padding bits, R5
    w = mkWord(p, i / 32, seed);
    return w[23-k];
  endfunction

  function automatic logic [23:0] expCh(input int mode, input int c, input int seed);
    if (mode <= 1) return (c < 8) ? mkWord(c / 2, c % 2, seed) : 24'd0;
    if (mode == 2) return (c < 8) ? mkWord(3, c, seed) : mkWord(2, c - 8, seed);
    return mkWord(2, c, seed);
  endfunction

  function automatic int frameLen(input int mode);
    if (mode <= 1) return 64;
    if (mode == 2) return 256;
    return 512;
  endfunction

  function automatic logic lrAt(input int mode, input int i);
    if (mode == 0) return (i >= 32);
    if (mode == 1) return (i < 32);
    return (i == 0);
  endfunction

  task automatic checkVal(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkData(input string tag, input logic [383:0] act, input int mode, input int seed);
    int bad;
    bad = -1;
    checks++;
    for (int c = 15; c >= 0; c--)
      if (act[c*24 +: 24] != expCh(mode, c, seed)) bad = c;
    if (bad >= 0) begin
      failures++;
      $display("FAIL %s channel %0d: actual=%h expected=%h", tag, bad,
               act[bad*24 +: 24], expCh(mode, bad, seed));
    end
  endtask

  task automatic writeFmt(input logic [2:0] v);
    @(negedge clk);
    ctrlWe = 1'b1;
    ctrlWdata = v;
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  task automatic bclkCycle(input logic lr, input logic [3:0] d);
    @(negedge clk);
    bclkIn = 1'b0;
    lrclkIn = lr;
    sdataIn = d;
    repeat (4) @(negedge clk);
    bclkIn = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic playStream(input int mode, input int nFrames, input int badIdx,
                            input int badLen, input int seed);
    logic [3:0] prevBit;
    logic [3:0] cur;
    int len;
    prevBit = 4'd0;
    repeat (4) bclkCycle((mode == 0), 4'd0);
    for (int k = 0; k <= nFrames; k++) begin
      len = (k == nFrames) ? 2 : ((k == badIdx) ? badLen : frameLen(mode));
      for (int i = 0; i < len; i++) begin
        for (int p = 0; p < 4; p++) cur[p] = genBit(p, i, seed);
        bclkCycle(lrAt(mode, i), (mode == 0) ? prevBit : cur);  // I2S lags one bit
        prevBit = cur;
      end
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic mainSeq();
    int base;
    // R1 reset state
    repeat (3) @(negedge clk);
    checkVal("R1", "frameValid in reset", int'(frameValid), 0);
    checkVal("R1", "frameErr in reset", int'(frameErr), 0);
    checkVal("R1", "chanData zero in reset", int'(chanData != '0), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    for (int r = 0; r < 6; r++) begin
      writeFmt(3'(RUNS[r][0]));
      base = validTotal;
      playStream(RUNS[r][0], RUNS[r][1], RUNS[r][2], RUNS[r][3], RUNS[r][4]);
      checkVal(RUNS[r][6] != 0 ? "R9" : "R8", "pulse count", validTotal - base, RUNS[r][5]);
      checkVal("R9", "error flag", int'(frameErr), RUNS[r][6]);
      checkData(RUNS[r][0] >= 2 ? "R6/R7/R10/R5" : "R3/R4/R5", capData, RUNS[r][0], RUNS[r][4]);
    end

    // R2 reserved code while error is set and format is I2S
    writeFmt(3'd5);
    checkVal("R2", "error kept after reserved write", int'(frameErr), 1);
    base = validTotal;
    playStream(0, 2, 99, 0, 77);
    checkVal("R2", "pulse count after reserved write", validTotal - base, 2);
    checkData("R2", capData, 0, 77);
    checkVal("R9", "flag still sticky", int'(frameErr), 1);

    // R11 accepted write clears the flag
    writeFmt(3'd1);
    @(negedge clk);
    checkVal("R11", "error cleared by write", int'(frameErr), 0);

    // R1 reset mid-operation, then default format decodes I2S
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    checkVal("R1", "chanData cleared", int'(chanData != '0), 0);
    checkVal("R1", "frameErr cleared", int'(frameErr), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    base = validTotal;
    playStream(0, 1, 99, 0, 9);
    checkVal("R1", "default format pulses", validTotal - base, 1);
    checkData("R1", capData, 0, 9);

    checkVal("R8", "back-to-back valid cycles", doublePulse, 0);
  endtask

  initial begin
    fork
      mainSeq();
      begin
        repeat (200000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule